// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter whose refresh is accepted only during a trailing slice of each timeout period. A free-running counter advances once per clock from zero toward a fixed overflow count. Software must refresh it by writing a fixed key byte to a one-byte refresh port. If the write arrives too early, carries the wrong byte, or never arrives before the count ends, the block issues a one-clock internal reset request.

The open slice is chosen by a 2-bit size setting and always ends at overflow. A standby-enable bit set to 0 opens the whole period. The first refresh after reset, or after any reset request, is taken at any count before overflow. This gives start-up code one full period to make its first refresh without knowing where the window falls.

Top module: `windowed_watchdog`

## Requirements
- R1: With `OVF` = `OVF_COUNT`, the window is open when the count is at or above `OVF*(3-win_sel)/4`, using integer division. The `win_sel_i` codes are 00 = last 25%, 01 = last 50%, 10 = last 75% and 11 = the whole period. A key write one count below the boundary faults, and a key write at the boundary is accepted.
- R2: A write of the key 0xAC while the window is open raises no request and restarts the count from zero. The next overflow then follows a full `OVF` counts later.
- R3: A write of 0xAC while the window is closed, once the first refresh has been taken, raises `rst_req_o` in the cycle after the write.
- R4: A write of any byte other than 0xAC raises `rst_req_o` in the cycle after the write, whatever the window state and count.
- R5: The first 0xAC write after reset release is accepted at any count before overflow and restarts the count.
- R6: When `stby_en_i` is 0, the window is fully open for every `win_sel_i` value.
- R7: If the count reaches `OVF-1` with no accepted refresh in that cycle, `rst_req_o` is high for the following cycle.
- R8: `rst_req_o` lasts exactly one cycle. At the same time the count returns to zero and the first-refresh exception is re-armed.
- R9: An accepted refresh in the cycle where the count is `OVF-1` cancels that overflow. If a fault and an overflow fall in the same cycle, a single request is produced.
- R10: While `rst_n` is low, and right after it is released, `rst_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_sel_i | input | 2 | Size of the open window at the end of the period |
| stby_en_i | input | 1 | 0 opens the whole period, 1 honours `win_sel_i` |
| wr_en_i | input | 1 | One-cycle strobe for a write to the refresh port |
| wr_data_i | input | 8 | Byte written to the refresh port |
| rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
Two functions can fall in the same clock: the end-of-period overflow and a write to the refresh port, both at count `OVF-1`. The bench reaches that count by waiting exactly `OVF-1` idle cycles after a restart and then writing.

When the byte written is the key, the bench expects no request. It also expects the next overflow to come a full period later. When the byte is wrong, fault and overflow coincide, and the bench expects exactly one request pulse, low again in the next cycle.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   localparam logic [7:0] REFRESH_KEY = 8'hAC;
   localparam int         NUM_WIN     = 4;

   typedef enum logic [1:0] {
      WIN_LAST_QUARTER = 2'b00,
      WIN_LAST_HALF    = 2'b01,
      WIN_LAST_3Q      = 2'b10,
      WIN_WHOLE        = 2'b11
   } win_sel_e;

   // first count of the open window, for a given period and size code
   function automatic int win_start(input int ovf, input int code);
      return (ovf * (3 - code)) / 4;
   endfunction

endpackage

// File: rtl/wwdt_window.sv
module wwdt_window
   import wwdt_pkg::*;
#(
   parameter int OVF_COUNT = 64,
   parameter int CW        = $clog2(OVF_COUNT)
) (
   input  logic [CW-1:0] cnt_i,
   input  logic [1:0]    win_sel_i,
   input  logic          stby_en_i,
   output logic          open_o
);

   logic [CW-1:0] start_tbl [NUM_WIN];
   logic [NUM_WIN-1:0] past_start;

   generate
      for (genvar g = 0; g < NUM_WIN; g++) begin : g_bound
         localparam int START = win_start(OVF_COUNT, g);
         if (START == 0) begin : g_always
            assign start_tbl[g]  = '0;
            assign past_start[g] = 1'b1;
         end else begin : g_cmp
            assign start_tbl[g]  = CW'(START);
            assign past_start[g] = (cnt_i >= start_tbl[g]);
         end
      end
   endgenerate

   win_sel_e sel;
   assign sel = win_sel_e'(win_sel_i);

   always_comb begin
      if (!stby_en_i) open_o = 1'b1;
      else            open_o = past_start[sel];
   end

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
   parameter int OVF_COUNT = 64,
   parameter int CW        = $clog2(OVF_COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o,
   output logic          at_end_o
);

   localparam logic [CW-1:0] LAST = CW'(OVF_COUNT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o    = cnt_q;
   assign at_end_o = (cnt_q == LAST);

endmodule

// File: rtl/wwdt_refresh.sv
module wwdt_refresh
   import wwdt_pkg::*;
#(
   parameter logic [7:0] KEY = REFRESH_KEY
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic [7:0] wr_data_i,
   input  logic       win_open_i,
   input  logic       trip_i,
   output logic       refresh_ok_o,
   output logic       fault_o,
   output logic       first_o
);

   logic first_q;
   logic key_hit;

   assign key_hit      = wr_en_i && (wr_data_i == KEY);
   assign refresh_ok_o = key_hit && (first_q || win_open_i);
   assign fault_o      = wr_en_i && !refresh_ok_o;
   assign first_o      = first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            first_q <= 1'b1;
      else if (trip_i)       first_q <= 1'b1;
      else if (refresh_ok_o) first_q <= 1'b0;
   end

endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
   import wwdt_pkg::*;
#(
   parameter int         OVF_COUNT = 64,
   parameter logic [7:0] KEY       = REFRESH_KEY
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] win_sel_i,
   input  logic       stby_en_i,
   input  logic       wr_en_i,
   input  logic [7:0] wr_data_i,
   output logic       rst_req_o
);

   localparam int CW = $clog2(OVF_COUNT);

   generate
      if (OVF_COUNT < 4) begin : g_bad_ovf
         $error("OVF_COUNT must be at least 4");
      end
      if (KEY == 8'h00) begin : g_bad_key
         $error("KEY must be non-zero");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_end;
   logic          win_open;
   logic          refresh_ok;
   logic          fault;
   logic          first_q;
   logic          trip;
   logic          req_q;

   assign trip = fault || (at_end && !refresh_ok);

   wwdt_counter #(.OVF_COUNT(OVF_COUNT), .CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (trip || refresh_ok),
      .cnt_o    (cnt_q),
      .at_end_o (at_end)
   );

   wwdt_window #(.OVF_COUNT(OVF_COUNT), .CW(CW)) u_win (
      .cnt_i     (cnt_q),
      .win_sel_i (win_sel_i),
      .stby_en_i (stby_en_i),
      .open_o    (win_open)
   );

   wwdt_refresh #(.KEY(KEY)) u_ref (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en_i),
      .wr_data_i    (wr_data_i),
      .win_open_i   (win_open),
      .trip_i       (trip),
      .refresh_ok_o (refresh_ok),
      .fault_o      (fault),
      .first_o      (first_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= trip;
   end

   assign rst_req_o = req_q;

endmodule

// File: rtl/windowed_watchdog_chk.sv
module windowed_watchdog_chk #(
   parameter int         OVF_COUNT = 64,
   parameter logic [7:0] KEY       = 8'hAC,
   parameter int         CW        = $clog2(OVF_COUNT)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    wr_data,
   input logic          stby_en,
   input logic          rst_req,
   input logic [CW-1:0] cnt,
   input logic          first,
   input logic          win_open
);

   localparam logic [CW-1:0] LAST = CW'(OVF_COUNT - 1);

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_pulse_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == '0) && first);

   assert_bad_key_trips_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != KEY) |=> rst_req);

   assert_overflow_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST && !wr_en) |=> rst_req);

   assert_open_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == KEY && win_open) |=> (!rst_req && cnt == '0));

   assert_closed_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == KEY && !win_open && !first) |=> rst_req);

   assert_standby_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stby_en |-> win_open);

endmodule

bind windowed_watchdog windowed_watchdog_chk #(.OVF_COUNT(OVF_COUNT), .KEY(KEY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en_i),
   .wr_data  (wr_data_i),
   .stby_en  (stby_en_i),
   .rst_req  (rst_req_o),
   .cnt      (cnt_q),
   .first    (first_q),
   .win_open (win_open)
);

// File: tb/windowed_watchdog_bench.sv
module windowed_watchdog_bench;

   localparam time CLK_PERIOD = 10ns;
   localparam int  OVF        = 64;
   localparam int  WD_LIMIT   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] win_sel = 2'b00;
   logic       stby_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rst_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   windowed_watchdog #(.OVF_COUNT(OVF)) u_windowed_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_sel_i (win_sel),
      .stby_en_i (stby_en),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .rst_req_o (rst_req)
   );

   typedef struct packed {
      logic [1:0] sel;
      logic       stby;
      logic [7:0] at;
      logic [7:0] data;
      logic       fault;
      logic [3:0] req;
   } vec_t;

   // bounds for OVF=64: sel 00 -> 48, 01 -> 32, 10 -> 16, 11 -> 0
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 1'b1, 8'd47, 8'hAC, 1'b1, 4'd3},  // R3 just below the boundary
      '{2'b00, 1'b1, 8'd48, 8'hAC, 1'b0, 4'd1},  // R1 at the boundary
      '{2'b01, 1'b1, 8'd31, 8'hAC, 1'b1, 4'd3},  // R3
      '{2'b01, 1'b1, 8'd32, 8'hAC, 1'b0, 4'd1},  // R1
      '{2'b10, 1'b1, 8'd15, 8'hAC, 1'b1, 4'd3},  // R3
      '{2'b10, 1'b1, 8'd16, 8'hAC, 1'b0, 4'd1},  // R1
      '{2'b11, 1'b1, 8'd0,  8'hAC, 1'b0, 4'd1},  // R1 whole period open
      '{2'b11, 1'b1, 8'd63, 8'hAC, 1'b0, 4'd9},  // R9 refresh beats overflow
      '{2'b00, 1'b0, 8'd1,  8'hAC, 1'b0, 4'd6},  // R6 standby bit forces open
      '{2'b00, 1'b1, 8'd50, 8'h55, 1'b1, 4'd4},  // R4 wrong key in open window
      '{2'b11, 1'b1, 8'd20, 8'h00, 1'b1, 4'd4},  // R4 wrong key, whole window
      '{2'b00, 1'b1, 8'd63, 8'h12, 1'b1, 4'd9}   // R9 fault and overflow together
   };

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: rst_req=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // called just after a negedge; the next posedge samples the write
   task automatic do_write(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < WD_LIMIT) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run hung, done=0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(rst_req, 1'b0, "R10 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(rst_req, 1'b0, "R10 after release");

      for (int i = 0; i < NV; i++) begin
         do_reset();
         win_sel = VECS[i].sel;
         stby_en = VECS[i].stby;
         do_write(8'hAC);
         chk(rst_req, 1'b0, $sformatf("R5 first write, vector %0d", i));
         idle(int'(VECS[i].at));
         do_write(VECS[i].data);
         chk(rst_req, VECS[i].fault, $sformatf("R%0d vector %0d", VECS[i].req, i));
         @(negedge clk);
         chk(rst_req, 1'b0, $sformatf("R8 pulse width, vector %0d", i));
      end

      // R5: first write late in a closed region is accepted
      do_reset();
      win_sel = 2'b00;
      stby_en = 1'b1;
      idle(5);
      do_write(8'hAC);
      chk(rst_req, 1'b0, "R5 first write at count 5");
      idle(10);
      do_write(8'hAC);
      chk(rst_req, 1'b1, "R3 second write at count 10");
      @(negedge clk);
      chk(rst_req, 1'b0, "R8 one-cycle pulse");
      // R8: exception re-armed after the request
      idle(3);
      do_write(8'hAC);
      chk(rst_req, 1'b0, "R8 first-write exception re-armed");

      // R7: overflow with no refresh
      do_reset();
      do_write(8'hAC);
      idle(63);
      chk(rst_req, 1'b0, "R7 no request before last count");
      @(negedge clk);
      chk(rst_req, 1'b1, "R7 overflow request");
      @(negedge clk);
      chk(rst_req, 1'b0, "R8 overflow pulse ends");

      // R2/R9: refresh on the last count restarts a full period
      do_reset();
      do_write(8'hAC);
      idle(63);
      do_write(8'hAC);
      chk(rst_req, 1'b0, "R9 refresh on last count");
      idle(63);
      chk(rst_req, 1'b0, "R2 full period after refresh");
      @(negedge clk);
      chk(rst_req, 1'b1, "R2 overflow one period after refresh");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule